// File: doc/BRIEF.md
# GF(2^8) Weighted Parity Accumulator

This block computes RAID-style parity over a stripe of source blocks that arrive one after another as a byte stream. Each source byte is multiplied in GF(2^8) by a coefficient chosen for that source. The product is then folded into a running accumulator with one entry per byte position. Two accumulators can run side by side with separate coefficient sets, so a plain XOR parity and a weighted parity can both come out of a single pass. The result bytes of a destination leave the block while the last source streams through.

A command gives an opcode, the number of sources minus one, a block-size code and two arrays of sixteen 8-bit coefficients. Source beats follow with `src_valid`. Idle cycles between beats are allowed. The reduction polynomial sits in a small register that resets to 0x1D (x^8+x^4+x^3+x^2+1) and can be rewritten at any time. Fetching memory, parsing descriptors and data protection are handled elsewhere.

Top module: `gf_parity_acc`

## Requirements
- R1: After reset, `cmd_ready` is 1, `d1_valid`, `d2_valid` and `cmd_err` are 0, and the reduction polynomial is 0x1D.
- R2: A cycle with `poly_load` high replaces the polynomial's low byte with `poly_data`. Products after that point are reduced modulo x^8 + that byte.
- R3: Opcode 0x1A produces, on destination 1, byte j = XOR over sources i of gfmul(src_i[j], coef1[i]). Coefficient i sits at `cmd_coef1[8i+7:8i]`. With every coefficient set to 1, the result is plain XOR parity.
- R4: Opcode 0x1B produces destination 1 from `cmd_coef1` and destination 2 from `cmd_coef2` in one pass. `d2_valid` never rises for any other opcode.
- R5: The stripe holds `cmd_nsrc_m1`+1 sources (2 to 16). If opcode 0x1A or 0x1B arrives with `cmd_nsrc_m1`=0, it is rejected as an error. A single-source weighted result is obtained by sending the source twice with coefficient 0 on the second copy.
- R6: Every source block is BLK_BASE<<`cmd_blk` bytes long. With the defaults, code 0 gives 512 bytes and code 3 gives 4096 bytes.
- R7: Opcode 0x08 passes one source unchanged to destination 1. The source-count field is ignored and coefficients are not applied.
- R8: Any other opcode raises `cmd_err` for exactly the cycle after acceptance. It produces no output and leaves `cmd_ready` at 1.
- R9: The result for a byte is presented on dN_valid/dN_data exactly two cycles after that byte is accepted, and only while the last source is streaming. Idle cycles inside the stream only delay results.
- R10: On the first source of a stripe, the accumulator is loaded rather than XORed. A result therefore never depends on earlier commands.
- R11: Source beats offered while no command is active are dropped. They produce no output and do not affect the next command.
- R12: A command is taken only when `cmd_ready` is 1. `cmd_ready` falls in the cycle after a valid command is accepted and returns once the last byte of the last source has been accepted. A command offered while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_load | input | 1 | Write strobe for the reduction polynomial |
| poly_data | input | 8 | Low byte of the new reduction polynomial |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 8 | Opcode: 0x08 copy, 0x1A single weighted sum, 0x1B dual weighted sum |
| cmd_nsrc_m1 | input | 4 | Number of sources minus one |
| cmd_blk | input | 2 | Block-size code, length = BLK_BASE<<code bytes |
| cmd_coef1 | input | 128 | Sixteen coefficients for destination 1, entry i at bits 8i+7:8i |
| cmd_coef2 | input | 128 | Sixteen coefficients for destination 2, same layout |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| src_valid | input | 1 | Source beat present |
| src_data | input | 8*DATA_BYTES | Source beat |
| d1_valid | output | 1 | Destination 1 result beat valid |
| d1_data | output | 8*DATA_BYTES | Destination 1 result beat |
| d2_valid | output | 1 | Destination 2 result beat valid |
| d2_data | output | 8*DATA_BYTES | Destination 2 result beat |

## Verification
The bench targets the stripe edges. It runs sixteen sources, where a counter that is off by one would drop or add a source and corrupt every byte. It runs the two-copy single-source case, where a coefficient of 0 must cancel a product instead of passing it. It runs back-to-back commands over the same byte positions, where a missing load-on-first would leak the previous stripe into the next result. It also checks 4096-byte blocks, copy with a nonzero source count, a polynomial other than the default, rejected opcodes and commands offered while busy. A wrong block length, a second-destination leak or a hold-state error each shows up as a mismatched or missing result beat in the per-cycle comparison.

// File: rtl/gfpa_pkg.sv
package gfpa_pkg;
  localparam logic [7:0] OP_COPY   = 8'h08;
  localparam logic [7:0] OP_SINGLE = 8'h1A;
  localparam logic [7:0] OP_DUAL   = 8'h1B;
  localparam int NSRC = 16;

  // multiply by x, then reduce with the low byte of the field polynomial
  function automatic logic [7:0] gf_xtime(input logic [7:0] a, input logic [7:0] poly);
    return a[7] ? ({a[6:0], 1'b0} ^ poly) : {a[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/gfpa_gfmul.sv
module gfpa_gfmul (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [7:0] poly,
  output logic [7:0] p
);
  import gfpa_pkg::*;

  logic [7:0] part [9];
  logic [7:0] sum  [9];

  assign part[0] = a;
  assign sum[0]  = 8'h00;
  for (genvar i = 0; i < 8; i++) begin : g_stage
    assign part[i+1] = gf_xtime(part[i], poly);
    assign sum[i+1]  = b[i] ? (sum[i] ^ part[i]) : sum[i];
  end
  assign p = sum[8];

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_MUL_BY_ONE: assert (b != 8'h01 || p == a); // R3
      AST_MUL_BY_ZERO: assert (b != 8'h00 || p == 8'h00); // R5
    end
  end
endmodule

// File: rtl/gfpa_acc.sv
module gfpa_acc #(
  parameter int DATA_BYTES = 1,
  parameter int AW = 12,
  localparam int W = 8 * DATA_BYTES,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_idx,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [W-1:0]  in_data,
  input  logic [7:0]    in_coef,
  input  logic [7:0]    poly,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  prod, s1_prod, rd_q, sum;
  logic [AW-1:0] s1_idx;
  logic          s1_v, s1_first, s1_last;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    gfpa_gfmul u_mul (
      .clk(clk), .rst(rst),
      .a(in_data[b*8 +: 8]), .b(in_coef), .poly(poly),
      .p(prod[b*8 +: 8])
    );
  end

  assign sum = s1_first ? s1_prod : (rd_q ^ s1_prod);

  // block-RAM style: synchronous read, one write port
  always_ff @(posedge clk) begin
    if (s1_v) mem[s1_idx] <= sum;
    rd_q <= mem[in_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_first  <= 1'b0;
      s1_last   <= 1'b0;
      s1_idx    <= '0;
      s1_prod   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      s1_v      <= in_valid;
      s1_first  <= in_first;
      s1_last   <= in_last;
      s1_idx    <= in_idx;
      s1_prod   <= prod;
      out_valid <= s1_v & s1_last;
      if (s1_v && s1_last) out_data <= sum;
    end
  end
endmodule

// File: rtl/gf_parity_acc.sv
module gf_parity_acc #(
  parameter int DATA_BYTES = 1,
  parameter int BLK_BASE = 512,
  parameter int MAX_CODE = 3,
  parameter logic [7:0] POLY_RESET = 8'h1D,
  localparam int NSRC = gfpa_pkg::NSRC,
  localparam int CNTW = $clog2(NSRC),
  localparam int W = 8 * DATA_BYTES,
  localparam int BLK_WORDS = BLK_BASE / DATA_BYTES,
  localparam int AW = $clog2(BLK_WORDS << MAX_CODE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poly_load,
  input  logic [7:0]        poly_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [CNTW-1:0]   cmd_nsrc_m1,
  input  logic [1:0]        cmd_blk,
  input  logic [NSRC*8-1:0] cmd_coef1,
  input  logic [NSRC*8-1:0] cmd_coef2,
  output logic              cmd_err,
  input  logic              src_valid,
  input  logic [W-1:0]      src_data,
  output logic              d1_valid,
  output logic [W-1:0]      d1_data,
  output logic              d2_valid,
  output logic [W-1:0]      d2_data
);
  import gfpa_pkg::*;

  logic            busy, dual_q, is_copy, op_ok, accept, beat;
  logic [7:0]      poly_q;
  logic [7:0]      coef1_q [NSRC];
  logic [7:0]      coef2_q [NSRC];
  logic [CNTW-1:0] nsrc_q, src_cnt;
  logic [AW-1:0]   last_idx_q, idx_q;
  logic [1:0]      dv;
  logic [W-1:0]    dd [2];

  function automatic logic [AW-1:0] last_of(input logic [1:0] code);
    int eff, n;
    eff = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    n = (BLK_WORDS << eff) - 1;
    return AW'(n);
  endfunction

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & ~busy;
  assign beat      = busy & src_valid;
  assign is_copy   = (cmd_op == OP_COPY);

  always_comb begin
    unique case (cmd_op)
      OP_COPY:            op_ok = 1'b1;
      OP_SINGLE, OP_DUAL: op_ok = (cmd_nsrc_m1 != '0);
      default:            op_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      dual_q     <= 1'b0;
      cmd_err    <= 1'b0;
      poly_q     <= POLY_RESET;
      nsrc_q     <= '0;
      src_cnt    <= '0;
      idx_q      <= '0;
      last_idx_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        coef1_q[i] <= 8'h00;
        coef2_q[i] <= 8'h00;
      end
    end else begin
      cmd_err <= accept & ~op_ok;
      if (poly_load) poly_q <= poly_data;
      if (accept && op_ok) begin
        busy       <= 1'b1;
        dual_q     <= (cmd_op == OP_DUAL);
        nsrc_q     <= is_copy ? '0 : cmd_nsrc_m1;
        last_idx_q <= last_of(cmd_blk);
        src_cnt    <= '0;
        idx_q      <= '0;
        for (int i = 0; i < NSRC; i++) begin
          coef1_q[i] <= is_copy ? 8'h01 : cmd_coef1[i*8 +: 8];
          coef2_q[i] <= cmd_coef2[i*8 +: 8];
        end
      end else if (beat) begin
        if (idx_q == last_idx_q) begin
          idx_q   <= '0;
          src_cnt <= src_cnt + 1'b1;
          if (src_cnt == nsrc_q) busy <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dest
    logic       lane_en;
    logic [7:0] lane_coef;
    assign lane_en   = beat & ((d == 0) | dual_q);
    assign lane_coef = (d == 0) ? coef1_q[src_cnt] : coef2_q[src_cnt];
    gfpa_acc #(.DATA_BYTES(DATA_BYTES), .AW(AW)) u_acc (
      .clk(clk), .rst(rst),
      .in_valid(lane_en), .in_idx(idx_q),
      .in_first(src_cnt == '0), .in_last(src_cnt == nsrc_q),
      .in_data(src_data), .in_coef(lane_coef), .poly(poly_q),
      .out_valid(dv[d]), .out_data(dd[d])
    );
  end

  assign d1_valid = dv[0];
  assign d1_data  = dd[0];
  assign d2_valid = dv[1];
  assign d2_data  = dd[1];

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && op_ok) |=> !cmd_ready); // R12
  AST_ERR_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> cmd_ready); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx_q <= last_idx_q)); // R6
  AST_SRC_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (src_cnt <= nsrc_q)); // R5
  AST_D2_WITH_D1: assert property (@(posedge clk) disable iff (rst)
    d2_valid |-> d1_valid); // R4
endmodule

// File: tb/sim_gf_parity_acc.sv
`timescale 1ns/1ps
module sim_gf_parity_acc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         poly_load, cmd_valid, src_valid;
  logic [7:0]   poly_data, cmd_op, src_data;
  logic [3:0]   cmd_nsrc_m1;
  logic [1:0]   cmd_blk;
  logic [127:0] cmd_coef1, cmd_coef2;
  logic         cmd_ready, cmd_err, d1_valid, d2_valid;
  logic [7:0]   d1_data, d2_data;

  always #10 clk = ~clk;

  gf_parity_acc u0 (
    .clk(clk), .rst(rst), .poly_load(poly_load), .poly_data(poly_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_nsrc_m1(cmd_nsrc_m1), .cmd_blk(cmd_blk),
    .cmd_coef1(cmd_coef1), .cmd_coef2(cmd_coef2), .cmd_err(cmd_err),
    .src_valid(src_valid), .src_data(src_data),
    .d1_valid(d1_valid), .d1_data(d1_data),
    .d2_valid(d2_valid), .d2_data(d2_data)
  );

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string cur_req = "R1";
  int    poly_m = 'h1D;
  int    acc1 [4096];
  int    acc2 [4096];
  int    c1 [16];
  int    c2 [16];
  bit    same_src = 0;
  bit    poke_busy = 0;

  // reference pipeline: drv_* describe the beat being driven now
  logic       drv_v1, drv_v2, drv_err, st_v1, st_v2, exp_v1, exp_v2, exp_err;
  logic [7:0] drv_d1, drv_d2, st_d1, st_d2, exp_d1, exp_d2;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // carry-less product followed by long division by the field polynomial
  function automatic int gfm(input int a, input int b, input int poly);
    int full = 0;
    for (int i = 0; i < 8; i++) if ((b >> i) & 1) full ^= (a << i);
    for (int k = 14; k >= 8; k--) if ((full >> k) & 1) full ^= ((256 | poly) << (k - 8));
    return full & 255;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int s, input int j);
    return 8'(seed * 101 + s * 37 + j * 13 + (j >> 3) * 7 + s * j);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      st_v1 = 0; st_v2 = 0; exp_v1 = 0; exp_v2 = 0; exp_err = 0;
      st_d1 = 0; st_d2 = 0; exp_d1 = 0; exp_d2 = 0;
    end else begin
      exp_v1 = st_v1; exp_d1 = st_d1; exp_v2 = st_v2; exp_d2 = st_d2;
      exp_err = drv_err;
      st_v1 = drv_v1; st_d1 = drv_d1; st_v2 = drv_v2; st_d2 = drv_d2;
    end
    if (cycles == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(d1_valid === exp_v1, cur_req, "d1_valid", d1_valid, exp_v1);
      if (exp_v1) check(d1_data === exp_d1, cur_req, "d1_data", d1_data, exp_d1);
      check(d2_valid === exp_v2, cur_req, "d2_valid", d2_valid, exp_v2);
      if (exp_v2) check(d2_data === exp_d2, cur_req, "d2_data", d2_data, exp_d2);
      check(cmd_err === exp_err, cur_req, "cmd_err", cmd_err, exp_err);
    end
  end

  task automatic tick();
    @(negedge clk);
    src_valid = 0; cmd_valid = 0; poly_load = 0;
    drv_v1 = 0; drv_v2 = 0; drv_err = 0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int nsm1, input int code,
                         input int seed, input bit gaps);
    bit ok, dual, copy, fresh;
    int ns, len, p;
    logic [7:0] b;
    copy = (op == 8'h08);
    dual = (op == 8'h1B);
    ok = copy || ((op == 8'h1A || dual) && nsm1 != 0);
    ns = copy ? 0 : nsm1;
    len = 512 << code;
    tick();
    cmd_valid = 1; cmd_op = op; cmd_nsrc_m1 = 4'(nsm1); cmd_blk = 2'(code);
    for (int i = 0; i < 16; i++) begin
      cmd_coef1[i*8 +: 8] = 8'(c1[i]);
      cmd_coef2[i*8 +: 8] = 8'(c2[i]);
    end
    drv_err = !ok;
    tick();
    check(cmd_ready === !ok, ok ? "R12" : "R8", "cmd_ready after command", cmd_ready, !ok);
    if (ok) begin
      fresh = 1;
      for (int s = 0; s <= ns; s++) begin
        for (int j = 0; j < len; j++) begin
          if (!fresh) tick();
          fresh = 0;
          if (gaps && (j % 5 == 2)) tick();
          b = pat(seed, same_src ? 0 : s, j);
          src_valid = 1; src_data = b;
          if (poke_busy && s == 0 && j == 10) begin
            cmd_valid = 1; cmd_op = 8'h55;
          end
          p = copy ? int'(b) : gfm(int'(b), c1[s], poly_m);
          acc1[j] = (s == 0) ? p : (acc1[j] ^ p);
          drv_v1 = (s == ns); drv_d1 = 8'(acc1[j]);
          if (dual) begin
            p = gfm(int'(b), c2[s], poly_m);
            acc2[j] = (s == 0) ? p : (acc2[j] ^ p);
            drv_v2 = (s == ns); drv_d2 = 8'(acc2[j]);
          end
        end
      end
      tick();
      check(cmd_ready === 1'b1, "R12", "cmd_ready after stripe", cmd_ready, 1);
    end
    tick();
    tick();
  endtask

  task automatic idle_src(input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      src_valid = 1; src_data = 8'(k * 53 + 9);
    end
    tick(); tick();
  endtask

  initial begin
    src_valid = 0; cmd_valid = 0; poly_load = 0; poly_data = 0;
    cmd_op = 0; cmd_nsrc_m1 = 0; cmd_blk = 0; cmd_coef1 = 0; cmd_coef2 = 0;
    src_data = 0; drv_v1 = 0; drv_v2 = 0; drv_err = 0; drv_d1 = 0; drv_d2 = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(cmd_ready === 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    check(d1_valid === 1'b0, "R1", "d1_valid", d1_valid, 0);
    check(d2_valid === 1'b0, "R1", "d2_valid", d2_valid, 0);
    check(cmd_err === 1'b0, "R1", "cmd_err", cmd_err, 0);

    // R3: all-ones coefficients give plain XOR parity (default polynomial)
    for (int i = 0; i < 16; i++) begin c1[i] = 1; c2[i] = 0; end
    cur_req = "R3";
    run_cmd(8'h1A, 2, 0, 1, 0);

    // R3: weighted sum with varied coefficients
    for (int i = 0; i < 16; i++) c1[i] = (i * 29 + 3) & 255;
    c1[1] = 8'h80; c1[2] = 8'hFF;
    run_cmd(8'h1A, 3, 0, 2, 0);

    // R9: idle cycles inside the stream
    cur_req = "R9";
    run_cmd(8'h1A, 2, 0, 3, 1);

    // R4: dual destinations in one pass
    for (int i = 0; i < 16; i++) begin c1[i] = 1; c2[i] = (i * 71 + 2) & 255; end
    cur_req = "R4";
    run_cmd(8'h1B, 2, 0, 4, 1);

    // R5: sixteen sources, then Q-only via zero coefficient on a repeated source
    cur_req = "R5";
    run_cmd(8'h1B, 15, 0, 5, 0);
    c1[0] = 8'h57; c1[1] = 0;
    same_src = 1;
    run_cmd(8'h1A, 1, 0, 6, 0);
    same_src = 0;
    run_cmd(8'h1A, 0, 0, 7, 0);

    // R6: 4096-byte blocks
    cur_req = "R6";
    for (int i = 0; i < 16; i++) begin c1[i] = (i * 13 + 5) & 255; c2[i] = (i * 19 + 1) & 255; end
    run_cmd(8'h1B, 1, 3, 8, 0);

    // R7: copy ignores source count and coefficients
    cur_req = "R7";
    for (int i = 0; i < 16; i++) c1[i] = 8'hC3;
    run_cmd(8'h08, 5, 3, 9, 0);

    // R8: unsupported opcode; R11: beats while idle are dropped
    cur_req = "R8";
    run_cmd(8'h55, 2, 0, 10, 0);
    cur_req = "R11";
    idle_src(20);

    // R10: back-to-back stripes over the same positions
    cur_req = "R10";
    for (int i = 0; i < 16; i++) c1[i] = (i * 91 + 7) & 255;
    run_cmd(8'h1A, 2, 0, 11, 0);
    run_cmd(8'h1A, 1, 0, 12, 0);

    // R12: command offered while busy is ignored
    cur_req = "R12";
    poke_busy = 1;
    run_cmd(8'h1A, 1, 0, 13, 0);
    poke_busy = 0;

    // R2: different reduction polynomial
    cur_req = "R2";
    tick();
    poly_load = 1; poly_data = 8'h4D; poly_m = 'h4D;
    tick();
    for (int i = 0; i < 16; i++) c1[i] = (i * 47 + 130) & 255;
    run_cmd(8'h1A, 2, 0, 14, 0);

    // R1: reset restores the default polynomial
    tick();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    poly_m = 'h1D;
    cur_req = "R1";
    run_cmd(8'h1A, 1, 0, 15, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule